// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the date as eight packed BCD bytes: hundredths of a second, seconds, minutes, hours with a century flag, day of week, date, month and year. It advances once per cycle in which `tick_i` is high. `tick_i` is a single-cycle strobe at 100 Hz, derived upstream from a 32.768 kHz timebase. Hours run on a 24-hour clock. Month length is worked out from the month and the year, and February gains a 29th day in leap years.

A host reaches the fields through two ports. A load port writes one byte at a time into the running counters. A read port selects one byte of a shadow copy. The shadow copy follows the running counters one cycle behind. While `hold_i` is high the copy stops following, so a multi-byte read sees one consistent instant. The running counters keep counting during the hold, so no time is lost.

Top module: `bcd_cal_clock`

## Requirements
- R1: After reset, the hundredths, seconds, minutes and hours fields and the century flag read 00. Day of week, date and month read 01, and year reads 00, using the default reset parameters.
- R2: The select codes are: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. Byte 3 holds the hours in bits 5:0 and the century flag in bit 6. Bit 7 of byte 3 always reads 0.
- R3: Each tick advances hundredths 00..99. A wrap of hundredths advances seconds 00..59, a wrap of seconds advances minutes 00..59, and a wrap of minutes advances hours 00..23. All values are BCD.
- R4: When the hours wrap, day of week advances 1..7, with 7 followed by 1.
- R5: When the hours wrap on the last day of the month, the date returns to 01 and the month advances. Months 04, 06, 09 and 11 have 30 days. Months 01, 03, 05, 07, 08, 10 and 12 have 31 days.
- R6: February has 29 days when the year is divisible by four, including year 00, and 28 days otherwise.
- R7: Month 12 wraps to 01 and advances the year. When the year wraps from 99 to 00, the century flag toggles.
- R8: A write with `wr_en_i` high loads `wr_data_i` into the selected field of both the running counters and the copy. The value can be read one cycle later, with byte 3 bit 7 dropped. A tick in the same cycle as a write is discarded.
- R9: A write to the seconds field also clears the hundredths field.
- R10: While `hold_i` is high, `rd_data_o` does not change under ticks. Time keeps accumulating in the running counters. Host writes still update the copy during a hold.
- R11: While `hold_i` is low, the copy equals the running counters as they stood one cycle earlier. After `hold_i` falls, the copy is refreshed at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 100 Hz single-cycle count strobe |
| hold_i | input | 1 | Freeze the host-visible copy |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 3 | Field select for writes |
| wr_data_i | input | 8 | BCD write data |
| rd_sel_i | input | 3 | Field select for reads |
| rd_data_o | output | 8 | Selected byte of the copy |

## Verification
The bench uses the default reset parameters: 00:00:00.00 on day 1, 01/01 of year 00. Reaching any rollover from that state would take far too many ticks, so every rollover is reached by loading all eight fields through the write port just short of a boundary and then applying a few ticks. This covers every month length class, leap and common Februaries (including year 00 and years with an odd tens digit), and the century toggle in both directions. One vector runs 150 ticks to cross two second boundaries. Directed cases cover a write and a tick in the same cycle, the seconds write clearing the hundredths, and the one-cycle refresh after a hold ends.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int unsigned FIELDS = 8;
  localparam int unsigned SEL_W  = $clog2(FIELDS);
  localparam int unsigned CENTURY_BIT = 6;

  typedef logic [7:0] bcd_byte_t;

  typedef enum logic [SEL_W-1:0] {
    F_CENTI = 3'd0,
    F_SEC   = 3'd1,
    F_MIN   = 3'd2,
    F_HOUR  = 3'd3,
    F_DOW   = 3'd4,
    F_DATE  = 3'd5,
    F_MONTH = 3'd6,
    F_YEAR  = 3'd7
  } field_e;

  function automatic bcd_byte_t field_mask(logic [SEL_W-1:0] sel);
    return (sel == F_HOUR) ? 8'h7f : 8'hff;
  endfunction

  function automatic bcd_byte_t bcd_inc(bcd_byte_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/bcd_cal_step.sv
module bcd_cal_step
  import bcd_cal_pkg::*;
(
  input  bcd_byte_t val_i,
  input  bcd_byte_t hi_i,
  output logic      top_o,
  output bcd_byte_t inc_o
);
  // >= so an out-of-range loaded value still wraps
  assign top_o = (val_i >= hi_i);
  assign inc_o = bcd_inc(val_i);
endmodule

// File: rtl/bcd_cal_mlen.sv
module bcd_cal_mlen
  import bcd_cal_pkg::*;
(
  input  bcd_byte_t month_i,
  input  bcd_byte_t year_i,
  output bcd_byte_t mlen_o
);
  logic leap;

  // divisible by 4: even tens -> units 0/4/8, odd tens -> units 2/6
  always_comb begin
    if (!year_i[4])
      leap = (year_i[3:0] == 4'd0) || (year_i[3:0] == 4'd4) || (year_i[3:0] == 4'd8);
    else
      leap = (year_i[3:0] == 4'd2) || (year_i[3:0] == 4'd6);
  end

  always_comb begin
    unique case (month_i)
      8'h02:                      mlen_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: mlen_o = 8'h30;
      default:                    mlen_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_cal_snap.sv
module bcd_cal_snap
  import bcd_cal_pkg::*;
#(
  parameter bcd_byte_t RST_DOW   = 8'h01,
  parameter bcd_byte_t RST_DATE  = 8'h01,
  parameter bcd_byte_t RST_MONTH = 8'h01,
  parameter bcd_byte_t RST_YEAR  = 8'h00
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       hold_i,
  input  logic [FIELDS-1:0][7:0]     live_i,
  input  logic                       wr_en_i,
  input  logic [SEL_W-1:0]           wr_sel_i,
  input  bcd_byte_t                  wr_data_i,
  output logic [FIELDS-1:0][7:0]     snap_o
);
  logic [FIELDS-1:0][7:0] snap_q, snap_d;

  always_comb begin
    snap_d = hold_i ? snap_q : live_i;
    if (wr_en_i) begin
      snap_d[wr_sel_i] = wr_data_i & field_mask(wr_sel_i);
      if (wr_sel_i == F_SEC) snap_d[F_CENTI] = 8'h00;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      snap_q <= {RST_YEAR, RST_MONTH, RST_DATE, RST_DOW, 32'h0};
    else
      snap_q <= snap_d;
  end

  assign snap_o = snap_q;
endmodule

// File: rtl/bcd_cal_clock.sv
module bcd_cal_clock
  import bcd_cal_pkg::*;
#(
  parameter bcd_byte_t RST_DOW   = 8'h01,
  parameter bcd_byte_t RST_DATE  = 8'h01,
  parameter bcd_byte_t RST_MONTH = 8'h01,
  parameter bcd_byte_t RST_YEAR  = 8'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [7:0]       wr_data_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [7:0]       rd_data_o
);
  logic [FIELDS-1:0][7:0] live_q, live_d, snap;
  logic [FIELDS-1:0][7:0] lo, hi, cur, inc;
  logic [FIELDS-1:0]      at_top, en, cy;
  bcd_byte_t              mlen;

  bcd_cal_mlen u_mlen (
    .month_i (live_q[F_MONTH]),
    .year_i  (live_q[F_YEAR]),
    .mlen_o  (mlen)
  );

  always_comb begin
    lo = {8'h00, 8'h01, 8'h01, 8'h01, 32'h0};
    hi = {8'h99, 8'h12, mlen, 8'h07, 8'h23, 8'h59, 8'h59, 8'h99};
    cur = live_q;
    cur[F_HOUR] = {2'b00, live_q[F_HOUR][5:0]};
  end

  for (genvar g = 0; g < FIELDS; g++) begin : g_step
    bcd_cal_step u_step (
      .val_i (cur[g]),
      .hi_i  (hi[g]),
      .top_o (at_top[g]),
      .inc_o (inc[g])
    );
  end

  // carry chain; date shares the hour carry with day of week
  always_comb begin
    for (int i = 0; i < FIELDS; i++) begin
      if (i == 0)           en[i] = tick_i && !wr_en_i;
      else if (i == F_DATE) en[i] = cy[F_HOUR];
      else                  en[i] = cy[i-1];
      cy[i] = en[i] && at_top[i];
    end
  end

  always_comb begin
    for (int i = 0; i < FIELDS; i++)
      live_d[i] = !en[i] ? cur[i] : (at_top[i] ? lo[i] : inc[i]);
    live_d[F_HOUR][CENTURY_BIT] = live_q[F_HOUR][CENTURY_BIT] ^ cy[F_YEAR];
    if (wr_en_i) begin
      live_d[wr_sel_i] = wr_data_i & field_mask(wr_sel_i);
      if (wr_sel_i == F_SEC) live_d[F_CENTI] = 8'h00;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      live_q <= {RST_YEAR, RST_MONTH, RST_DATE, RST_DOW, 32'h0};
    else
      live_q <= live_d;
  end

  bcd_cal_snap #(
    .RST_DOW   (RST_DOW),
    .RST_DATE  (RST_DATE),
    .RST_MONTH (RST_MONTH),
    .RST_YEAR  (RST_YEAR)
  ) u_snap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (hold_i),
    .live_i    (live_q),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .snap_o    (snap)
  );

  assign rd_data_o = snap[rd_sel_i];
endmodule

// File: rtl/bcd_cal_clock_chk.sv
module bcd_cal_clock_chk
  import bcd_cal_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hold_i,
  input logic             wr_en_i,
  input logic [SEL_W-1:0] wr_sel_i,
  input logic [7:0]       wr_data_i,
  input logic [SEL_W-1:0] rd_sel_i,
  input logic [7:0]       rd_data_o
);
  // R8
  write_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_sel_i != $past(wr_sel_i)) ||
                (rd_data_o == ($past(wr_data_i) & field_mask($past(wr_sel_i)))));

  // R9
  sec_write_centi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == F_SEC) |=> (rd_sel_i != F_CENTI) || (rd_data_o == 8'h00));

  // R10
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hold_i) && !$past(wr_en_i) && $stable(rd_sel_i)) |-> $stable(rd_data_o));

  // R3
  centi_bcd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == F_CENTI) |-> (rd_data_o[3:0] <= 4'd9 && rd_data_o[7:4] <= 4'd9));

  // R2
  hour_bit7_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == F_HOUR) |-> !rd_data_o[7]);
endmodule

bind bcd_cal_clock bcd_cal_clock_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hold_i    (hold_i),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .rd_sel_i  (rd_sel_i),
  .rd_data_o (rd_data_o)
);

// File: tb/test_bcd_cal_clock.sv
module test_bcd_cal_clock;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       hold_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_sel_i = 3'd0;
  logic [7:0] wr_data_i = 8'h00;
  logic [2:0] rd_sel_i = 3'd0;
  logic [7:0] rd_data_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  bcd_cal_clock i_bcd_cal_clock (
    .clk_i, .rst_ni, .tick_i, .hold_i, .wr_en_i,
    .wr_sel_i, .wr_data_i, .rd_sel_i, .rd_data_o
  );

  // {year,month,date,dow,hour,min,sec,centi} start, tick count, expected
  localparam int VN = 17;
  localparam logic [143:0] VECS [VN] = '{
    {64'h00_01_01_01_00_00_00_98, 16'd3,   64'h00_01_01_01_00_00_01_01},
    {64'h21_03_15_07_23_59_59_99, 16'd1,   64'h21_03_16_01_00_00_00_00},
    {64'h21_04_30_03_23_59_59_99, 16'd1,   64'h21_05_01_04_00_00_00_00},
    {64'h21_01_31_02_23_59_59_99, 16'd1,   64'h21_02_01_03_00_00_00_00},
    {64'h23_02_28_01_23_59_59_99, 16'd1,   64'h23_03_01_02_00_00_00_00},
    {64'h24_02_28_03_23_59_59_99, 16'd1,   64'h24_02_29_04_00_00_00_00},
    {64'h24_02_29_04_23_59_59_99, 16'd1,   64'h24_03_01_05_00_00_00_00},
    {64'h00_02_28_06_23_59_59_99, 16'd1,   64'h00_02_29_07_00_00_00_00},
    {64'h45_12_31_02_23_59_59_99, 16'd1,   64'h46_01_01_03_00_00_00_00},
    {64'h99_12_31_05_23_59_59_99, 16'd1,   64'h00_01_01_06_40_00_00_00},
    {64'h99_12_31_05_63_59_59_99, 16'd1,   64'h00_01_01_06_00_00_00_00},
    {64'h17_08_21_04_10_09_59_50, 16'd150, 64'h17_08_21_04_10_10_01_00},
    {64'h22_11_30_03_23_59_59_99, 16'd1,   64'h22_12_01_04_00_00_00_00},
    {64'h22_06_30_03_23_59_59_99, 16'd1,   64'h22_07_01_04_00_00_00_00},
    {64'h36_02_29_05_23_59_59_99, 16'd1,   64'h36_03_01_06_00_00_00_00},
    {64'h34_02_28_01_23_59_59_99, 16'd1,   64'h34_03_01_02_00_00_00_00},
    {64'h09_05_31_07_23_59_59_99, 16'd1,   64'h09_06_01_01_00_00_00_00}
  };
  string vec_tag [VN];

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [7:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      @(negedge clk_i);
      tick_i = 1'b1;
      repeat (n) @(negedge clk_i);
      tick_i = 1'b0;
    end
  endtask

  task automatic rd_chk(string tag, logic [2:0] sel, logic [7:0] exp);
    @(negedge clk_i);
    rd_sel_i = sel;
    #1;
    check(tag, rd_data_o, exp);
  endtask

  task automatic load_all(logic [63:0] t);
    for (int s = 7; s >= 0; s--) wr(3'(s), t[s*8 +: 8]);
  endtask

  initial begin
    vec_tag = '{"R3", "R4", "R5", "R5", "R6", "R6", "R6", "R6", "R7",
                "R7", "R7", "R3", "R5", "R5", "R6", "R6", "R5"};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset values, R2 field order
    rd_chk("R1 centi", 3'd0, 8'h00);
    rd_chk("R1 sec",   3'd1, 8'h00);
    rd_chk("R1 min",   3'd2, 8'h00);
    rd_chk("R1 hour",  3'd3, 8'h00);
    rd_chk("R2 dow",   3'd4, 8'h01);
    rd_chk("R2 date",  3'd5, 8'h01);
    rd_chk("R2 month", 3'd6, 8'h01);
    rd_chk("R1 year",  3'd7, 8'h00);

    for (int v = 0; v < VN; v++) begin
      load_all(VECS[v][143:80]);
      ticks(int'(VECS[v][79:64]));
      @(negedge clk_i);
      for (int s = 0; s < 8; s++)
        rd_chk(vec_tag[v], 3'(s), VECS[v][s*8 +: 8]);
    end

    // R2 bit 7 of hour byte dropped
    wr(3'd3, 8'hE3);
    rd_chk("R2 hour bit7", 3'd3, 8'h63);

    // R8 tick coinciding with a write is discarded
    load_all(64'h10_10_10_02_10_10_10_00);
    @(negedge clk_i);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 3'd2; wr_data_i = 8'h30;
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b0;
    @(negedge clk_i);
    rd_chk("R8 centi", 3'd0, 8'h00);
    rd_chk("R8 min",   3'd2, 8'h30);

    // R9 seconds write clears hundredths
    wr(3'd0, 8'h55);
    rd_chk("R9 pre", 3'd0, 8'h55);
    wr(3'd1, 8'h20);
    rd_chk("R9 centi", 3'd0, 8'h00);
    rd_chk("R9 sec",   3'd1, 8'h20);

    // R10 hold freezes copy, counters keep going
    load_all(64'h10_10_10_02_10_10_00_00);
    @(negedge clk_i);
    hold_i = 1'b1;
    ticks(100);
    rd_chk("R10 sec held",   3'd1, 8'h00);
    rd_chk("R10 centi held", 3'd0, 8'h00);
    wr(3'd2, 8'h44);
    rd_chk("R10 write in hold", 3'd2, 8'h44);
    rd_chk("R10 sec still held", 3'd1, 8'h00);
    // R11 refresh one edge after release
    @(negedge clk_i);
    rd_sel_i = 3'd1;
    hold_i = 1'b0;
    #1;
    check("R11 before edge", rd_data_o, 8'h00);
    @(negedge clk_i);
    #1;
    check("R11 after edge", rd_data_o, 8'h01);
    rd_chk("R11 min", 3'd2, 8'h44);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule